// File: doc/BRIEF.md
# Reservation Station with Tag Wakeup

This block holds decoded instructions between issue and execution. Each instruction is accepted together with the register-file read data for its two sources. A source whose register holds a committed value is stored as that value. A source whose register is still awaiting a result is stored as the register index, which acts as a wakeup tag. A result bus carries a register index and a value. Every waiting source whose tag equals that index takes the value and becomes valid.

A small status table inside the block keeps one bit per architectural register. Issuing an instruction marks its destination as pending, and a result broadcast to that register marks it as available again. Once both sources of an entry are valid, the entry can go to the execution unit. One entry is dispatched per cycle, and the oldest ready entry goes first.

A build-time switch selects how an instruction that finds the station empty is handled. With bypass enabled, such an instruction goes straight to the execution unit in the same cycle if both of its operands are already available. Otherwise every instruction spends at least one cycle in the station. The issuer must not rename: it never issues a new writer to a register that is still pending.

Top module: `rsv_station`

## Requirements
- R1: After reset the station holds no entries, `iss_ready` is 1, `dsp_valid` is 0, and all 32 registers are marked available.
- R2: A source whose register is marked available is taken from the register-file data presented with the issue, and that value appears on `dsp_a` (source 1) or `dsp_b` (source 2) at dispatch.
- R3: A source whose register is pending waits as a tag. When `bc_valid` is high with `bc_tag` equal to that register, the entry stores `bc_value`, and the instruction dispatches with that value in a later cycle.
- R4: An entry is dispatched only after both of its sources are valid. The broadcast that completes an entry makes it eligible in the following cycle.
- R5: When several entries are ready, the one issued earliest is dispatched first, whichever storage slot it occupies. At most one instruction is dispatched per cycle.
- R6: An accepted issue marks its destination register pending, so a later reader of that register waits for a tag. A broadcast to that register marks it available again, so a still later reader takes the register-file data.
- R7: A broadcast in the same cycle as an issue is applied to the incoming instruction's sources. The instruction does not wait for a tag that is on the bus in that cycle.
- R8: `iss_ready` is 0 when all 8 entries are occupied and no entry is dispatched from the station in that cycle. A dispatch from a full station raises `iss_ready` in that same cycle. An issue presented while `iss_ready` is 0 is dropped.
- R9: With `BYPASS`=1, an instruction presented to an empty station with both sources available (including by R7) appears on the dispatch outputs in the same cycle and occupies no entry.
- R10: With `BYPASS`=0, an issued instruction is dispatched no earlier than the cycle after it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | An instruction is presented for issue |
| iss_ready | output | 1 | The station can accept an instruction this cycle |
| iss_op | input | 6 | Opcode of the incoming instruction |
| iss_rd | input | 5 | Destination register of the incoming instruction |
| iss_rs1 | input | 5 | First source register |
| iss_rs2 | input | 5 | Second source register |
| rf_data1 | input | 32 | Register-file data read for the first source |
| rf_data2 | input | 32 | Register-file data read for the second source |
| bc_valid | input | 1 | A result is on the broadcast bus |
| bc_tag | input | 5 | Destination register of the broadcast result |
| bc_value | input | 32 | Broadcast result value |
| dsp_valid | output | 1 | An instruction is sent to the execution unit |
| dsp_op | output | 6 | Opcode of the dispatched instruction |
| dsp_rd | output | 5 | Destination register of the dispatched instruction |
| dsp_a | output | 32 | First operand of the dispatched instruction |
| dsp_b | output | 32 | Second operand of the dispatched instruction |

## Verification
Issue and result broadcast can land in the same cycle. The bench provokes this by putting a result for a register on the bus in the very cycle a consumer of that register is issued with wrong register-file data. It judges the case by requiring the bypassed dispatch in that cycle to carry the broadcast value. Issue and station dispatch also collide when the station is full: eight waiting entries are woken by one broadcast, and the bench requires `iss_ready` to be high in the cycle of the first dispatch. A ninth instruction offered while the station is full must never reach the dispatch outputs.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
    parameter int XLEN  = 32;
    parameter int NREG  = 32;
    parameter int OPW   = 6;
    parameter int DEPTH = 8;

    localparam int RW = $clog2(NREG);
    localparam int AW = $clog2(DEPTH);

    typedef logic [XLEN-1:0] word_t;
    typedef logic [RW-1:0]   rid_t;
    typedef logic [OPW-1:0]  op_t;
    typedef logic [AW-1:0]   age_t;

    // operand: value when ok=1, producer register index in the low bits when ok=0
    typedef struct packed {
        logic  ok;
        word_t data;
    } opnd_t;

    typedef struct packed {
        logic  vld;
        op_t   op;
        rid_t  rd;
        opnd_t s1;
        opnd_t s2;
    } slot_t;

    typedef struct packed {
        logic  vld;
        rid_t  tag;
        word_t value;
    } bcast_t;

    // source capture at issue: result bus first, then the committed register value
    function automatic opnd_t capture_src(rid_t idx, logic reg_ok, word_t rf_val, bcast_t bc);
        opnd_t o;
        if (bc.vld && bc.tag == idx) begin
            o.ok   = 1'b1;
            o.data = bc.value;
        end else if (reg_ok) begin
            o.ok   = 1'b1;
            o.data = rf_val;
        end else begin
            o.ok   = 1'b0;
            o.data = {{(XLEN-RW){1'b0}}, idx};
        end
        return o;
    endfunction

    // associative wakeup of a waiting operand
    function automatic opnd_t wake(opnd_t o, bcast_t bc);
        opnd_t n;
        n = o;
        if (!o.ok && bc.vld && o.data[RW-1:0] == bc.tag) begin
            n.ok   = 1'b1;
            n.data = bc.value;
        end
        return n;
    endfunction
endpackage

// File: rtl/rsv_scoreboard.sv
module rsv_scoreboard
    import rsv_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            set_en,
    input  rid_t            set_id,
    input  logic            clr_en,
    input  rid_t            clr_id,
    output logic [NREG-1:0] reg_ok
);
    always_ff @(posedge clk) begin
        if (rst) begin
            reg_ok <= '1;
        end else begin
            if (set_en) reg_ok[set_id] <= 1'b1;
            // a new writer issued in the same cycle keeps the register pending
            if (clr_en) reg_ok[clr_id] <= 1'b0;
        end
    end
endmodule

// File: rtl/rsv_slot.sv
module rsv_slot
    import rsv_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   alloc,
    input  slot_t  alloc_data,
    input  logic   take,
    input  bcast_t bc,
    input  logic   grow,
    input  logic   shrink,
    input  age_t   shrink_age,
    output slot_t  cur,
    output age_t   age,
    output logic   ready
);
    // age = number of valid entries younger than this one
    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
            age <= '0;
        end else if (alloc) begin
            cur <= alloc_data;
            age <= '0;
        end else if (take) begin
            cur.vld <= 1'b0;
        end else if (cur.vld) begin
            cur.s1 <= wake(cur.s1, bc);
            cur.s2 <= wake(cur.s2, bc);
            age    <= age + AW'(grow) - AW'(shrink && (age > shrink_age));
        end
    end

    assign ready = cur.vld && cur.s1.ok && cur.s2.ok;
endmodule

// File: rtl/rsv_pick.sv
module rsv_pick
    import rsv_pkg::*;
(
    input  logic [DEPTH-1:0]         ready,
    input  logic [DEPTH-1:0][AW-1:0] ages,
    output logic [DEPTH-1:0]         grant,
    output logic                     found,
    output age_t                     gage
);
    logic [AW-1:0] best;

    always_comb begin
        found = 1'b0;
        best  = '0;
        gage  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (ready[i] && (!found || ages[i] > gage)) begin
                found = 1'b1;
                best  = AW'(i);
                gage  = ages[i];
            end
        end
        grant = found ? (DEPTH'(1) << best) : '0;
    end
endmodule

// File: rtl/rsv_station.sv
module rsv_station
    import rsv_pkg::*;
#(
    parameter int BYPASS = 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            iss_valid,
    output logic            iss_ready,
    input  logic [OPW-1:0]  iss_op,
    input  logic [RW-1:0]   iss_rd,
    input  logic [RW-1:0]   iss_rs1,
    input  logic [RW-1:0]   iss_rs2,
    input  logic [XLEN-1:0] rf_data1,
    input  logic [XLEN-1:0] rf_data2,
    input  logic            bc_valid,
    input  logic [RW-1:0]   bc_tag,
    input  logic [XLEN-1:0] bc_value,
    output logic            dsp_valid,
    output logic [OPW-1:0]  dsp_op,
    output logic [RW-1:0]   dsp_rd,
    output logic [XLEN-1:0] dsp_a,
    output logic [XLEN-1:0] dsp_b
);
    bcast_t                   bc;
    logic [NREG-1:0]          reg_ok;
    opnd_t                    in1, in2;
    slot_t                    incoming;
    slot_t                    slots [DEPTH];
    slot_t                    pick_slot;
    logic [DEPTH-1:0][AW-1:0] ages;
    logic [DEPTH-1:0]         vld_vec, rdy_vec, ok1_vec, ok2_vec;
    logic [DEPTH-1:0]         grant, free_oh, alloc_oh;
    logic                     st_found;
    age_t                     gage;
    logic                     empty, full, iss_fire, byp_go, byp_take, park;

    assign bc = '{vld: bc_valid, tag: bc_tag, value: bc_value};

    rsv_scoreboard u_sb (
        .clk    (clk),
        .rst    (rst),
        .set_en (bc_valid),
        .set_id (bc_tag),
        .clr_en (iss_fire),
        .clr_id (iss_rd),
        .reg_ok (reg_ok)
    );

    assign in1 = capture_src(iss_rs1, reg_ok[iss_rs1], rf_data1, bc);
    assign in2 = capture_src(iss_rs2, reg_ok[iss_rs2], rf_data2, bc);
    assign incoming = '{vld: 1'b1, op: iss_op, rd: iss_rd, s1: in1, s2: in2};

    assign empty     = ~|vld_vec;
    assign full      = &vld_vec;
    assign iss_ready = !full || st_found;
    assign iss_fire  = iss_valid && iss_ready;

    generate
        if (BYPASS != 0) begin : g_bypass
            assign byp_go = empty && in1.ok && in2.ok;
        end else begin : g_straight
            assign byp_go = 1'b0;
        end
    endgenerate

    assign byp_take = iss_fire && byp_go;
    assign park     = iss_fire && !byp_go;

    // lowest slot that is free now or freed by this cycle's dispatch
    always_comb begin
        free_oh = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!vld_vec[i] || grant[i]) free_oh = DEPTH'(1) << i;
        end
    end
    assign alloc_oh = park ? free_oh : '0;

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            rsv_slot u_slot (
                .clk        (clk),
                .rst        (rst),
                .alloc      (alloc_oh[g]),
                .alloc_data (incoming),
                .take       (grant[g]),
                .bc         (bc),
                .grow       (park),
                .shrink     (st_found),
                .shrink_age (gage),
                .cur        (slots[g]),
                .age        (ages[g]),
                .ready      (rdy_vec[g])
            );
            assign vld_vec[g] = slots[g].vld;
            assign ok1_vec[g] = slots[g].s1.ok;
            assign ok2_vec[g] = slots[g].s2.ok;
        end
    endgenerate

    rsv_pick u_pick (
        .ready (rdy_vec),
        .ages  (ages),
        .grant (grant),
        .found (st_found),
        .gage  (gage)
    );

    always_comb begin
        pick_slot = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (grant[i]) pick_slot = slots[i];
        end
    end

    assign dsp_valid = st_found || byp_take;

    always_comb begin
        if (byp_take) begin
            dsp_op = iss_op;
            dsp_rd = iss_rd;
            dsp_a  = in1.data;
            dsp_b  = in2.data;
        end else begin
            dsp_op = pick_slot.op;
            dsp_rd = pick_slot.rd;
            dsp_a  = pick_slot.s1.data;
            dsp_b  = pick_slot.s2.data;
        end
    end
endmodule

// File: rtl/rsv_station_chk.sv
module rsv_station_chk
    import rsv_pkg::*;
#(
    parameter int BYPASS = 1
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     iss_valid,
    input logic                     iss_ready,
    input logic                     dsp_valid,
    input logic [DEPTH-1:0]         vld_vec,
    input logic [DEPTH-1:0]         ok1_vec,
    input logic [DEPTH-1:0]         ok2_vec,
    input logic [DEPTH-1:0]         grant,
    input logic [DEPTH-1:0][AW-1:0] ages
);
    logic [DEPTH-1:0] full_ok;
    logic             older_skipped;

    assign full_ok = vld_vec & ok1_vec & ok2_vec;

    always_comb begin
        older_skipped = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            for (int j = 0; j < DEPTH; j++) begin
                if (grant[i] && full_ok[j] && ages[j] > ages[i]) older_skipped = 1'b1;
            end
        end
    end

    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (vld_vec == '0)); // R1

    AST_OPERAND_STICKY: assert property (@(posedge clk) disable iff (rst)
        ((vld_vec & ok1_vec & ok2_vec) & $past(full_ok & ~grant)) == $past(full_ok & ~grant)); // R3

    AST_DISP_BOTH_VALID: assert property (@(posedge clk) disable iff (rst)
        (grant & ~full_ok) == '0); // R4

    AST_OLDEST_FIRST: assert property (@(posedge clk) disable iff (rst)
        !older_skipped); // R5

    AST_ONE_DISPATCH: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant)); // R5

    AST_ONE_ALLOC: assert property (@(posedge clk) disable iff (rst)
        $countones(vld_vec & ~$past(vld_vec)) <= 1); // R8

    AST_STALL_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
        !iss_ready |-> (&vld_vec)); // R8

    AST_BYPASS_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (BYPASS != 0 && dsp_valid && grant == '0) |-> (iss_valid && vld_vec == '0)); // R9

    AST_NO_BYPASS: assert property (@(posedge clk) disable iff (rst)
        (BYPASS == 0 && dsp_valid) |-> (grant != '0)); // R10
endmodule

bind rsv_station rsv_station_chk #(.BYPASS(BYPASS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .iss_valid (iss_valid),
    .iss_ready (iss_ready),
    .dsp_valid (dsp_valid),
    .vld_vec   (vld_vec),
    .ok1_vec   (ok1_vec),
    .ok2_vec   (ok2_vec),
    .grant     (grant),
    .ages      (ages)
);

// File: tb/tb_rsv_station.sv
module tb_rsv_station;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [5:0]  op;
        logic [4:0]  rd;
        logic [4:0]  rs1;
        logic [4:0]  rs2;
        logic [31:0] d1;
        logic [31:0] d2;
    } row_t;

    // independent instructions into an empty station: each bypasses in its cycle
    localparam row_t TBL [8] = '{
        {6'h01, 5'd16, 5'd1,  5'd2,  32'h1111_0001, 32'h2222_0002},
        {6'h02, 5'd17, 5'd3,  5'd4,  32'hDEAD_BEEF, 32'h0000_0000},
        {6'h03, 5'd18, 5'd5,  5'd5,  32'hFFFF_FFFF, 32'hFFFF_FFFF},
        {6'h04, 5'd19, 5'd0,  5'd15, 32'h8000_0000, 32'h0000_0001},
        {6'h3F, 5'd20, 5'd9,  5'd8,  32'h0123_4567, 32'h89AB_CDEF},
        {6'h00, 5'd21, 5'd10, 5'd11, 32'h5555_5555, 32'hAAAA_AAAA},
        {6'h15, 5'd22, 5'd12, 5'd13, 32'h0000_00FF, 32'hFF00_0000},
        {6'h2A, 5'd23, 5'd14, 5'd7,  32'h7FFF_FFFF, 32'h1357_9BDF}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        iss_valid = 1'b0;
    logic [5:0]  iss_op = '0;
    logic [4:0]  iss_rd = '0, iss_rs1 = '0, iss_rs2 = '0;
    logic [31:0] rf_data1 = '0, rf_data2 = '0;
    logic        bc_valid = 1'b0;
    logic [4:0]  bc_tag = '0;
    logic [31:0] bc_value = '0;

    logic        iss_ready, dsp_valid;
    logic [5:0]  dsp_op;
    logic [4:0]  dsp_rd;
    logic [31:0] dsp_a, dsp_b;
    logic        sf_iss_ready, sf_dsp_valid;
    logic [5:0]  sf_dsp_op;
    logic [4:0]  sf_dsp_rd;
    logic [31:0] sf_dsp_a, sf_dsp_b;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rsv_station #(.BYPASS(1)) dut (
        .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_ready(iss_ready),
        .iss_op(iss_op), .iss_rd(iss_rd), .iss_rs1(iss_rs1), .iss_rs2(iss_rs2),
        .rf_data1(rf_data1), .rf_data2(rf_data2),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_value(bc_value),
        .dsp_valid(dsp_valid), .dsp_op(dsp_op), .dsp_rd(dsp_rd),
        .dsp_a(dsp_a), .dsp_b(dsp_b)
    );

    rsv_station #(.BYPASS(0)) dut_sf (
        .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_ready(sf_iss_ready),
        .iss_op(iss_op), .iss_rd(iss_rd), .iss_rs1(iss_rs1), .iss_rs2(iss_rs2),
        .rf_data1(rf_data1), .rf_data2(rf_data2),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_value(bc_value),
        .dsp_valid(sf_dsp_valid), .dsp_op(sf_dsp_op), .dsp_rd(sf_dsp_rd),
        .dsp_a(sf_dsp_a), .dsp_b(sf_dsp_b)
    );

    task automatic check(string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    // each driver task applies its inputs at a falling edge and returns 1 time unit later
    task automatic drive(logic iv, logic [5:0] op, logic [4:0] rd, logic [4:0] rs1, logic [4:0] rs2,
                         logic [31:0] d1, logic [31:0] d2, logic bv, logic [4:0] tag, logic [31:0] val);
        @(negedge clk);
        iss_valid = iv; iss_op = op; iss_rd = rd; iss_rs1 = rs1; iss_rs2 = rs2;
        rf_data1 = d1; rf_data2 = d2;
        bc_valid = bv; bc_tag = tag; bc_value = val;
        #1;
    endtask

    task automatic issue(logic [5:0] op, logic [4:0] rd, logic [4:0] rs1, logic [4:0] rs2,
                         logic [31:0] d1, logic [31:0] d2);
        drive(1'b1, op, rd, rs1, rs2, d1, d2, 1'b0, '0, '0);
    endtask

    task automatic bcast(logic [4:0] tag, logic [31:0] val);
        drive(1'b0, '0, '0, '0, '0, '0, '0, 1'b1, tag, val);
    endtask

    task automatic idle();
        drive(1'b0, '0, '0, '0, '0, '0, '0, 1'b0, '0, '0);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check("R1 iss_ready", 32'(iss_ready), 32'd1);
        check("R1 dsp_valid", 32'(dsp_valid), 32'd0);
        check("R1 sf iss_ready", 32'(sf_iss_ready), 32'd1);
        check("R1 sf dsp_valid", 32'(sf_dsp_valid), 32'd0);

        // R9 / R10: bypass versus straightforward on an empty station
        issue(6'h09, 5'd20, 5'd1, 5'd2, 32'hA000_0001, 32'hB000_0002);
        check("R9 bypass valid", 32'(dsp_valid), 32'd1);
        check("R9 R2 bypass a", dsp_a, 32'hA000_0001);
        check("R9 R2 bypass b", dsp_b, 32'hB000_0002);
        check("R10 no same-cycle dispatch", 32'(sf_dsp_valid), 32'd0);
        idle();
        check("R10 dispatch next cycle", 32'(sf_dsp_valid), 32'd1);
        check("R10 op", 32'(sf_dsp_op), 32'h09);
        check("R10 R2 a", sf_dsp_a, 32'hA000_0001);
        check("R9 no repeat", 32'(dsp_valid), 32'd0);
        bcast(5'd20, 32'h0);

        // R2 / R9 table walk
        for (int k = 0; k < 8; k++) begin
            issue(TBL[k].op, TBL[k].rd, TBL[k].rs1, TBL[k].rs2, TBL[k].d1, TBL[k].d2);
            check("R9 table valid", 32'(dsp_valid), 32'd1);
            check("R2 table op", 32'(dsp_op), 32'(TBL[k].op));
            check("R2 table rd", 32'(dsp_rd), 32'(TBL[k].rd));
            check("R2 table a", dsp_a, TBL[k].d1);
            check("R2 table b", dsp_b, TBL[k].d2);
        end
        for (int k = 0; k < 8; k++) bcast(TBL[k].rd, 32'h0);

        // R3 / R4 / R6: tag wait and wakeup
        issue(6'h02, 5'd10, 5'd1, 5'd2, 32'h1, 32'h2);
        check("R9 producer bypass", 32'(dsp_valid), 32'd1);
        issue(6'h03, 5'd11, 5'd10, 5'd3, 32'hBAD0_BAD0, 32'h3333_0003);
        check("R6 pending source waits", 32'(dsp_valid), 32'd0);
        idle();
        check("R4 still waiting", 32'(dsp_valid), 32'd0);
        idle();
        check("R4 still waiting 2", 32'(dsp_valid), 32'd0);
        bcast(5'd10, 32'hC0DE_0010);
        check("R4 not in broadcast cycle", 32'(dsp_valid), 32'd0);
        idle();
        check("R3 woken valid", 32'(dsp_valid), 32'd1);
        check("R3 woken op", 32'(dsp_op), 32'h03);
        check("R3 woken a", dsp_a, 32'hC0DE_0010);
        check("R3 woken b", dsp_b, 32'h3333_0003);
        check("R3 woken rd", 32'(dsp_rd), 32'd11);
        bcast(5'd11, 32'h0);
        issue(6'h04, 5'd14, 5'd10, 5'd3, 32'h7777_0010, 32'h3);
        check("R6 restored valid", 32'(dsp_valid), 32'd1);
        check("R6 restored a", dsp_a, 32'h7777_0010);
        bcast(5'd14, 32'h0);

        // R7: broadcast and issue in the same cycle
        issue(6'h05, 5'd12, 5'd1, 5'd2, 32'h1, 32'h2);
        drive(1'b1, 6'h06, 5'd13, 5'd12, 5'd2, 32'hBAD1_BAD1, 32'h2, 1'b1, 5'd12, 32'h0F0F_1212);
        check("R7 forward valid", 32'(dsp_valid), 32'd1);
        check("R7 forward a", dsp_a, 32'h0F0F_1212);
        check("R7 forward op", 32'(dsp_op), 32'h06);
        bcast(5'd13, 32'h0);

        // R5: age order beats slot order
        issue(6'h10, 5'd5, 5'd1, 5'd2, 32'h1, 32'h2);
        issue(6'h10, 5'd6, 5'd1, 5'd2, 32'h1, 32'h2);
        issue(6'h20, 5'd24, 5'd6, 5'd1, 32'h0, 32'h11);
        issue(6'h21, 5'd21, 5'd5, 5'd1, 32'h0, 32'h11);
        issue(6'h22, 5'd22, 5'd5, 5'd1, 32'h0, 32'h11);
        bcast(5'd6, 32'h6666_0006);
        idle();
        check("R3 first woken op", 32'(dsp_op), 32'h20);
        check("R3 first woken a", dsp_a, 32'h6666_0006);
        issue(6'h23, 5'd23, 5'd5, 5'd1, 32'h0, 32'h11);
        check("R9 no bypass when occupied", 32'(dsp_valid), 32'd0);
        bcast(5'd5, 32'h5555_0005);
        idle();
        check("R5 oldest first", 32'(dsp_op), 32'h21);
        check("R5 oldest a", dsp_a, 32'h5555_0005);
        idle();
        check("R5 second", 32'(dsp_op), 32'h22);
        idle();
        check("R5 youngest last", 32'(dsp_op), 32'h23);
        check("R5 youngest valid", 32'(dsp_valid), 32'd1);
        for (int k = 21; k <= 24; k++) bcast(5'(k), 32'h0);

        // R8: full station
        issue(6'h2F, 5'd7, 5'd1, 5'd2, 32'h1, 32'h2);
        for (int k = 0; k < 8; k++) begin
            issue(6'(6'h30 + k), 5'(16 + k), 5'd7, 5'd1, 32'h0, 32'h1);
            check("R8 room left", 32'(iss_ready), 32'd1);
        end
        issue(6'h3F, 5'd30, 5'd7, 5'd1, 32'h0, 32'h1);
        check("R8 full stalls", 32'(iss_ready), 32'd0);
        bcast(5'd7, 32'h7777_7777);
        check("R8 full still stalls", 32'(iss_ready), 32'd0);
        idle();
        check("R8 dispatch frees", 32'(iss_ready), 32'd1);
        check("R8 dispatch valid", 32'(dsp_valid), 32'd1);
        check("R5 drain 0", 32'(dsp_op), 32'h30);
        for (int k = 1; k < 8; k++) begin
            idle();
            check("R5 drain order", 32'(dsp_op), 32'(6'h30 + k));
        end
        idle();
        check("R8 dropped issue absent", 32'(dsp_valid), 32'd0);
        for (int k = 16; k < 24; k++) bcast(5'(k), 32'h0);

        finish_run();
    end
endmodule